// File: doc/BRIEF.md
# Page-Table DMA Address Translator

This block maps a device-side DMA address onto a system address using a table of 64-bit translation entries kept in registers inside the block, one entry per I/O page. A page holds 2^PAGE_SHIFT bytes, 4 KiB by default. The I/O address is taken relative to the start of the translation window. Its page number selects an entry. The entry's upper bits, with the in-page bits cleared, give the system page base. The entry's two lowest bits give the access rights.

A requester offers an address and an access kind (read or write) on a valid/ready request channel. One cycle after acceptance, a registered result appears on a valid/ready response channel. The result holds the translated page base, the in-page mask, the page-aligned I/O address, the permission and a fault flag. The flag is raised for a denied access and for a page outside the window. The response side is a two-state machine. IDLE means no result is held. HELD means a result is waiting. The transitions are:
- FILL (IDLE to HELD): a request is accepted.
- CHAIN (HELD to HELD): the result is consumed and a new request is accepted in the same cycle.
- STALL (HELD to HELD): the result is not consumed.
- DRAIN (HELD to IDLE): the result is consumed and no new request arrives.

Software fills the table through a side port. This port has a one-cycle write path and a combinational read path. The window length, in pages, is a live input.

Top module: `tce_xlate`

## Requirements
- R1: Reset clears every table entry to zero and leaves no response pending. Any request made after reset therefore faults.
- R2: For an in-range page, the page index is the request address shifted right by PAGE_SHIFT. The translated address is the selected entry with its low PAGE_SHIFT bits cleared.
- R3: For an in-range page, the returned I/O address is the request address with its low PAGE_SHIFT bits cleared. The returned mask is 2^PAGE_SHIFT−1.
- R4: The permission output equals the entry's bits [1:0]. The encoding is 00 none, 01 read only, 10 write only, 11 read and write. Bit 0 grants reads and bit 1 grants writes.
- R5: The fault output is 1 when a write request (req_wr=1) meets a clear bit 1, or when a read request (req_wr=0) meets a clear bit 0.
- R6: A page index at or beyond the window length returns permission 00, translated address 0, I/O address 0, an all-ones mask and fault 1.
- R7: When win_pages is 0, every request faults.
- R8: A result is valid in the cycle after its request is accepted. req_ready is 1 whenever no result is held or rsp_ready is 1. A consumed result with no new request leaves rsp_valid at 0.
- R9: While rsp_valid is 1 and rsp_ready is 0, every response field holds its value.
- R10: A side write to an index at or beyond NUM_ENT is ignored. A side read of such an index returns 0. A side read otherwise returns the stored entry. A lookup sees the table as it stood before any side write made in the same cycle.
- R11: A win_pages value above NUM_ENT acts as NUM_ENT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_pages | input | CW | Window length in pages |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | I/O address, relative to the window start |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Result consumed |
| rsp_xlat | output | EW | Translated page base |
| rsp_iova | output | AW | Page-aligned I/O address |
| rsp_mask | output | EW | In-page mask |
| rsp_perm | output | 2 | Permission code |
| rsp_fault | output | 1 | Access denied or page out of range |
| tw_en | input | 1 | Side write enable |
| tw_idx | input | CW | Side write index |
| tw_data | input | EW | Side write data |
| tr_idx | input | CW | Side read index |
| tr_data | output | EW | Side read data, combinational |

## Verification
Response fields and rsp_valid are due exactly one clock edge after the accepting edge. A side write becomes visible on tr_data after the edge that captures it. req_ready follows rsp_ready within the same cycle. The bench drives inputs 1 ns after each rising edge and holds a behavioural model that it advances on the same edge. It compares every output with the model at the falling edge, so each comparison lands in the cycle in which that value is due.

// File: rtl/tce_pkg.sv
package tce_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RD   = 2'b01,
        ACC_WR   = 2'b10,
        ACC_RW   = 2'b11
    } acc_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HELD = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/tce_table.sv
module tce_table #(
    parameter int NUM_ENT = 16,
    parameter int EW      = 64,
    parameter int CW      = 5,
    parameter int IDXW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_idx,
    input  logic [EW-1:0]   wr_data,
    input  logic [IDXW-1:0] lk_idx,
    output logic [EW-1:0]   lk_data,
    input  logic [CW-1:0]   sd_idx,
    output logic [EW-1:0]   sd_data
);
    localparam logic [CW-1:0] LIMIT = CW'(NUM_ENT);

    logic [EW-1:0] ent_q [NUM_ENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
        end else if (wr_en && (wr_idx < LIMIT)) begin
            ent_q[wr_idx[IDXW-1:0]] <= wr_data;
        end
    end

    always_comb begin
        lk_data = ent_q[lk_idx];
        sd_data = (sd_idx < LIMIT) ? ent_q[sd_idx[IDXW-1:0]] : '0;
    end
endmodule

// File: rtl/tce_lookup.sv
module tce_lookup
    import tce_pkg::*;
#(
    parameter int AW         = 32,
    parameter int EW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_ENT    = 16,
    parameter int CW         = 5,
    parameter int IDXW       = 4
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic [CW-1:0]   win_pages,
    output logic [IDXW-1:0] tbl_idx,
    input  logic [EW-1:0]   entry,
    output logic [EW-1:0]   xlat,
    output logic [AW-1:0]   iova,
    output logic [EW-1:0]   mask,
    output acc_e            perm,
    output logic            fault
);
    localparam int PIW  = AW - PAGE_SHIFT;
    localparam int CMPW = (PIW > CW) ? PIW : CW;
    localparam logic [EW-1:0] LOW_E = (EW'(1) << PAGE_SHIFT) - EW'(1);
    localparam logic [AW-1:0] LOW_A = (AW'(1) << PAGE_SHIFT) - AW'(1);
    localparam logic [CW-1:0] MAXP  = CW'(NUM_ENT);

    logic [PIW-1:0] page;
    logic [CW-1:0]  limit;
    logic           in_win;

    always_comb begin
        page    = addr[AW-1:PAGE_SHIFT];
        limit   = (win_pages > MAXP) ? MAXP : win_pages;
        in_win  = CMPW'(page) < CMPW'(limit);
        tbl_idx = page[IDXW-1:0];
        if (in_win) begin
            xlat = entry & ~LOW_E;
            iova = addr & ~LOW_A;
            mask = LOW_E;
            perm = acc_e'(entry[1:0]);
        end else begin
            xlat = '0;
            iova = '0;
            mask = '1;
            perm = ACC_NONE;
        end
        fault = wr ? ~perm[1] : ~perm[0];
    end
endmodule

// File: rtl/tce_rsp_fsm.sv
module tce_rsp_fsm
    import tce_pkg::*;
#(
    parameter int AW = 32,
    parameter int EW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          rsp_ready,
    output logic          rsp_valid,
    input  logic [EW-1:0] d_xlat,
    input  logic [AW-1:0] d_iova,
    input  logic [EW-1:0] d_mask,
    input  acc_e          d_perm,
    input  logic          d_fault,
    output logic [EW-1:0] q_xlat,
    output logic [AW-1:0] q_iova,
    output logic [EW-1:0] q_mask,
    output acc_e          q_perm,
    output logic          q_fault
);
    rsp_state_e st_q, st_d;
    logic       take;

    always_comb begin
        req_ready = (st_q == RS_IDLE) || rsp_ready;
        take      = req_valid && req_ready;
        st_d      = st_q;
        unique case (st_q)
            RS_IDLE: if (take) st_d = RS_HELD;
            RS_HELD: if (rsp_ready && !take) st_d = RS_IDLE;
            default: st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_xlat  <= '0;
            q_iova  <= '0;
            q_mask  <= '0;
            q_perm  <= ACC_NONE;
            q_fault <= 1'b0;
        end else if (take) begin
            q_xlat  <= d_xlat;
            q_iova  <= d_iova;
            q_mask  <= d_mask;
            q_perm  <= d_perm;
            q_fault <= d_fault;
        end
    end

    assign rsp_valid = (st_q == RS_HELD);
endmodule

// File: rtl/tce_xlate.sv
module tce_xlate
    import tce_pkg::*;
#(
    parameter int AW         = 32,
    parameter int EW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_ENT    = 16,
    localparam int IDXW      = $clog2(NUM_ENT),
    localparam int CW        = IDXW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] win_pages,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_wr,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [EW-1:0] rsp_xlat,
    output logic [AW-1:0] rsp_iova,
    output logic [EW-1:0] rsp_mask,
    output logic [1:0]    rsp_perm,
    output logic          rsp_fault,
    input  logic          tw_en,
    input  logic [CW-1:0] tw_idx,
    input  logic [EW-1:0] tw_data,
    input  logic [CW-1:0] tr_idx,
    output logic [EW-1:0] tr_data
);
    logic [IDXW-1:0] lk_idx;
    logic [EW-1:0]   lk_ent;
    logic [EW-1:0]   c_xlat, c_mask;
    logic [AW-1:0]   c_iova;
    acc_e            c_perm, r_perm;
    logic            c_fault;

    tce_table #(.NUM_ENT(NUM_ENT), .EW(EW), .CW(CW), .IDXW(IDXW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tw_en), .wr_idx(tw_idx), .wr_data(tw_data),
        .lk_idx(lk_idx), .lk_data(lk_ent),
        .sd_idx(tr_idx), .sd_data(tr_data)
    );

    tce_lookup #(.AW(AW), .EW(EW), .PAGE_SHIFT(PAGE_SHIFT), .NUM_ENT(NUM_ENT),
                 .CW(CW), .IDXW(IDXW)) u_look (
        .addr(req_addr), .wr(req_wr), .win_pages(win_pages),
        .tbl_idx(lk_idx), .entry(lk_ent),
        .xlat(c_xlat), .iova(c_iova), .mask(c_mask),
        .perm(c_perm), .fault(c_fault)
    );

    tce_rsp_fsm #(.AW(AW), .EW(EW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
        .d_xlat(c_xlat), .d_iova(c_iova), .d_mask(c_mask),
        .d_perm(c_perm), .d_fault(c_fault),
        .q_xlat(rsp_xlat), .q_iova(rsp_iova), .q_mask(rsp_mask),
        .q_perm(r_perm), .q_fault(rsp_fault)
    );

    assign rsp_perm = r_perm;
endmodule

// File: rtl/tce_xlate_chk.sv
module tce_xlate_chk #(
    parameter int AW         = 32,
    parameter int EW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] win_pages,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [EW-1:0] rsp_xlat,
    input logic [AW-1:0] rsp_iova,
    input logic [EW-1:0] rsp_mask,
    input logic [1:0]    rsp_perm,
    input logic          rsp_fault
);
    localparam logic [EW-1:0] LOW = (EW'(1) << PAGE_SHIFT) - EW'(1);

    a_r8_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_xlat) &&
            $stable(rsp_iova) && $stable(rsp_mask) && $stable(rsp_perm) &&
            $stable(rsp_fault)));

    a_r5_none_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == 2'b00) |-> rsp_fault);

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_xlat & LOW) == '0));

    a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_mask == LOW || rsp_mask == '1));

    a_r6_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_mask == '1) |-> (rsp_xlat == '0 && rsp_iova == '0 &&
            rsp_perm == 2'b00 && rsp_fault));

    a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && win_pages == '0) |=> rsp_fault);
endmodule

bind tce_xlate tce_xlate_chk #(.AW(AW), .EW(EW), .PAGE_SHIFT(PAGE_SHIFT), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .win_pages(win_pages),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_xlat(rsp_xlat), .rsp_iova(rsp_iova), .rsp_mask(rsp_mask),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
);

// File: tb/sim_tce_xlate.sv
`timescale 1ns/1ps
module sim_tce_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  win_pages = 5'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_xlat, rsp_mask;
    logic [31:0] rsp_iova;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;
    logic        tw_en = 1'b0;
    logic [4:0]  tw_idx = '0;
    logic [63:0] tw_data = '0;
    logic [4:0]  tr_idx = '0;
    logic [63:0] tr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tce_xlate u0 (.*);

    // behavioural reference model
    longint unsigned m_tab [16];
    bit              m_valid;
    longint unsigned m_xlat, m_mask;
    longint unsigned m_iova;
    int              m_perm;
    bit              m_fault;
    string           m_tag;
    bit              m_stall;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_tab[i] = 0;
            m_valid = 0; m_stall = 0; m_tag = "R1";
            m_xlat = 0; m_mask = 0; m_iova = 0; m_perm = 0; m_fault = 0;
        end else begin
            bit acc;
            acc = req_valid && (!m_valid || rsp_ready);
            m_stall = m_valid && !rsp_ready;
            if (acc) begin
                longint unsigned pg, lim, e;
                pg  = longint'(req_addr) / 4096;
                lim = (win_pages > 16) ? 16 : win_pages;
                if (pg < lim) begin
                    e      = m_tab[pg];
                    m_xlat = e - (e % 4096);
                    m_iova = longint'(req_addr) - (longint'(req_addr) % 4096);
                    m_mask = 4095;
                    m_perm = int'(e % 4);
                    m_tag  = (win_pages > 16) ? "R11" : "R2";
                end else begin
                    m_xlat = 0; m_iova = 0; m_perm = 0;
                    m_mask = 64'hFFFF_FFFF_FFFF_FFFF;
                    m_tag  = (win_pages == 0) ? "R7" : "R6";
                end
                if (req_wr) m_fault = (m_perm != 2) && (m_perm != 3);
                else        m_fault = (m_perm != 1) && (m_perm != 3);
                m_valid = 1;
            end else if (rsp_ready) begin
                m_valid = 0;
            end
            if (tw_en && tw_idx < 16) m_tab[tw_idx] = tw_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            longint unsigned tr_exp;
            t = m_stall ? "R9" : m_tag;
            chk(rsp_valid == m_valid, "R8", "rsp_valid", rsp_valid, m_valid);
            chk(req_ready == (!m_valid || rsp_ready), "R8", "req_ready",
                req_ready, (!m_valid || rsp_ready));
            if (m_valid) begin
                chk(rsp_xlat == m_xlat, t, "xlat", rsp_xlat, m_xlat);
                chk(rsp_iova == m_iova, (t == "R2") ? "R3" : t, "iova", rsp_iova, m_iova);
                chk(rsp_mask == m_mask, (t == "R2") ? "R3" : t, "mask", rsp_mask, m_mask);
                chk(rsp_perm == m_perm, (t == "R2") ? "R4" : t, "perm", rsp_perm, m_perm);
                chk(rsp_fault == m_fault, (t == "R2") ? "R5" : t, "fault", rsp_fault, m_fault);
            end
            tr_exp = (tr_idx < 16) ? m_tab[tr_idx] : 0;
            chk(tr_data == tr_exp, "R10", "tr_data", tr_data, tr_exp);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic req(input logic [31:0] a, input logic w);
        req_valid = 1; req_addr = a; req_wr = w;
        step();
        req_valid = 0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        report();
    end

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        // R1: table cleared after reset, requests fault
        for (int i = 0; i < 16; i++) begin
            tr_idx = 5'(i); step();
            chk(tr_data == 0, "R1", "entry after reset", tr_data, 0);
        end
        req(32'h0000_5123, 1'b0); step();
        chk(rsp_fault == 1, "R1", "fault after reset", rsp_fault, 1);
        // fill the table; perm of entry i is i%4
        for (int i = 0; i < 16; i++) begin
            tw_en = 1; tw_idx = 5'(i);
            tw_data = (64'h1234_5000_0000_0000 ^ (64'(i) * 64'h0101_0100_0000)) |
                      (64'(i) * 64'h1111);
            step();
        end
        // R10: out-of-range write ignored
        tw_idx = 5'd20; tw_data = 64'hDEAD_BEEF_DEAD_BEEF; step();
        tw_en = 0; tr_idx = 5'd20; step();
        chk(tr_data == 0, "R10", "read beyond table", tr_data, 0);
        tr_idx = 5'd3; step();
        // back-to-back lookups, reads and writes (R2..R5)
        req_valid = 1;
        for (int i = 0; i < 16; i++) begin
            req_addr = 32'(i * 4096 + (i * 37) % 4096); req_wr = 0; step();
            req_wr = 1; step();
        end
        // R6: beyond the window
        req_addr = 32'h0001_0000; step();
        req_addr = 32'hFFFF_F123; step();
        // R9: stalled response
        req_addr = 32'h0000_2ABC; req_wr = 0; step();
        rsp_ready = 0; repeat (3) step();
        rsp_ready = 1; step();
        // R6 with short window
        win_pages = 5; req_addr = 32'h0000_4010; step();
        req_addr = 32'h0000_5010; step();
        // R7: empty window
        win_pages = 0; req_addr = 32'h0000_0000; req_wr = 0; step();
        req_wr = 1; step();
        // R11: oversized window clamps
        win_pages = 31; req_addr = 32'h0000_F001; req_wr = 0; step();
        req_addr = 32'h0001_0001; step();
        req_valid = 0; win_pages = 16; step();
        // R10: lookup sees table before a same-cycle write
        tw_en = 1; tw_idx = 5'd1; tw_data = 64'h0000_0000_AAAA_B003;
        req_valid = 1; req_addr = 32'h0000_1000; req_wr = 1; step();
        tw_en = 0; step();
        req_valid = 0; step();
        // mixed traffic
        for (int k = 0; k < 300; k++) begin
            req_valid = 1'($urandom);
            rsp_ready = 1'($urandom);
            req_wr    = 1'($urandom);
            req_addr  = $urandom % 32'h0001_4000;
            win_pages = 5'($urandom % 20);
            tw_en     = (($urandom % 8) == 0);
            tw_idx    = 5'($urandom % 18);
            tw_data   = {$urandom, $urandom};
            tr_idx    = 5'($urandom % 18);
            step();
        end
        req_valid = 0; rsp_ready = 1; tw_en = 0;
        repeat (3) step();
        report();
    end
endmodule